// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the software-facing register bank of a small LCD controller. It sits on a 32-bit bus where one-cycle write strobes store data and read strobes return data in the same cycle. It holds a control word, three timing words, a status word and a subpanel word. It hands the decoded configuration (enable, load mode, panel type, mono, width, height) to a separate frame engine that fetches pixels and generates panel timing.

Setting or clearing the enable bit sends a one-cycle start or stop pulse to the frame engine. The engine reports back through two event inputs: palette loaded and sync error. These set sticky status flags. A single level interrupt output is formed from the flags and the two interrupt enable bits.

Readback is not a plain echo of the last write. Constant one-bits are ORed into the control, timing0 and timing2 images. Width and height are stored as the written field plus one and read back as the stored value minus one. At reset the stored dimensions are zero, so timing0 and timing1 read back as all ones.

Top module: `lcd_ctl_regs`

## Requirements
- R1: After reset the block reads as follows. Status reads 0, subpanel 0, control 0xFE000C34, timing0 and timing1 0xFFFFFFFF, timing2 0xFC000000. `irq`, `eng_start`, `eng_stop`, `cfg_enable` and `cfg_width` are all 0.
- R2: Control register (offset 0x00) fields:
  - A write takes load mode from bits 21:20, panel type from bit 7, interrupt enables from bits 4:3, mono from bit 1 and enable from bit 0.
  - The write also keeps the value ANDed with 0x01CFF300.
  - A read returns the panel-type bit at both bit 23 and bit 7, the other fields at their write positions, the kept bits, and 0xFE000C34 ORed in.
- R3: A timing0 (0x04) write stores bits 9:0 plus one as the width (`cfg_width`) and bits 31:10 as a timing field. A read returns (field << 10) | (width − 1, as 32 bits) | 0xF.
- R4: A timing1 (0x08) write stores bits 9:0 plus one as the height, read back the same way with no forced bits. Timing2 (0x0C) stores the whole word and reads back with bits 31:26 forced to one.
- R5: A subpanel (0x14) write stores the value ANDed with 0xA1FFFFFF.
- R6: The status register (0x10) is read-only and writes to it are ignored. Any offset other than the six above reads as zero, and writes to it change nothing. Status bit positions are: bit 6 palette loaded, bit 2 sync error, bit 0 frame done.
- R7: A control write that changes enable from 0 to 1 makes `eng_start` high for exactly the following cycle and clears frame done and palette loaded. A change from 1 to 0 makes `eng_stop` high for exactly one cycle. A write that leaves enable unchanged produces no pulse.
- R8: A 1-to-0 enable write clears sync error. It sets frame done unless the load mode written in that same word is 1.
- R9: An `evt_palette` pulse sets palette loaded at the next clock edge. An event that sets a flag in the same cycle as a clear of that flag wins.
- R10: An `evt_sync_err` pulse sets sync error and clears the enable bit at the next edge, without a stop pulse. If it coincides with a 0-to-1 enable write, no start pulse is issued.
- R11: `irq` is high exactly when one of the following holds:
  - frame done is set and enable bit 0 is set;
  - palette loaded is set and enable bit 1 is set;
  - sync error is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read |
| evt_palette | input | 1 | Frame engine: palette has been loaded |
| evt_sync_err | input | 1 | Frame engine: sync error detected |
| eng_start | output | 1 | One-cycle start pulse to frame engine |
| eng_stop | output | 1 | One-cycle stop pulse to frame engine |
| cfg_enable | output | 1 | Current enable bit |
| cfg_load_mode | output | 2 | Load mode field |
| cfg_tft | output | 1 | Panel type bit |
| cfg_mono | output | 1 | Mono bit |
| cfg_width | output | DIM_W+1 | Stored width (field plus one) |
| cfg_height | output | DIM_W+1 | Stored height (field plus one) |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the event inputs are single-cycle pulses from the frame engine, and that the bus strobes are sampled only at clock edges. They also assume that only one access (a read or a write) occurs per cycle. The bench drives every strobe and event on the falling edge for exactly one cycle and never overlaps a read with a write. The one deliberate exception is the collision cases, where an event is raised together with a control write so that the priority rules of R9 and R10 are exercised.

// File: rtl/lcd_reg_pkg.sv
package lcd_reg_pkg;

   localparam int unsigned REG_W = 32;

   // register offsets (byte addresses)
   localparam int unsigned OFF_CTRL = 'h00;
   localparam int unsigned OFF_TIM0 = 'h04;
   localparam int unsigned OFF_TIM1 = 'h08;
   localparam int unsigned OFF_TIM2 = 'h0C;
   localparam int unsigned OFF_STAT = 'h10;
   localparam int unsigned OFF_SUBP = 'h14;

   // control word field positions
   localparam int unsigned CB_EN     = 0;
   localparam int unsigned CB_MONO   = 1;
   localparam int unsigned CB_IEN    = 3;
   localparam int unsigned CB_TFT    = 7;
   localparam int unsigned CB_LMODE  = 20;
   localparam int unsigned CB_TFT_HI = 23;

   // masks and forced readback bits
   localparam logic [REG_W-1:0] CTRL_KEEP  = 32'h01CF_F300;
   localparam logic [REG_W-1:0] CTRL_ONES  = 32'hFE00_0C34;
   localparam logic [REG_W-1:0] TIM0_ONES  = 32'h0000_000F;
   localparam logic [REG_W-1:0] TIM2_ONES  = 32'hFC00_0000;
   localparam logic [REG_W-1:0] SUBP_KEEP  = 32'hA1FF_FFFF;

   // status bit positions
   localparam int unsigned SB_FRAME = 0;
   localparam int unsigned SB_SYNC  = 2;
   localparam int unsigned SB_PAL   = 6;

   // load mode value that suppresses frame-done on stop
   localparam logic [1:0] LMODE_PAL_ONLY = 2'd1;

   typedef enum logic [2:0] {
      SEL_CTRL,
      SEL_TIM0,
      SEL_TIM1,
      SEL_TIM2,
      SEL_STAT,
      SEL_SUBP,
      SEL_NONE
   } reg_sel_e;

   typedef struct packed {
      logic [1:0]       lmode;
      logic             tft;
      logic [1:0]       ien;
      logic             mono;
      logic             enable;
      logic [REG_W-1:0] kept;
   } ctl_fields_t;

   function automatic logic [REG_W-1:0] ctl_image(input ctl_fields_t c);
      logic [REG_W-1:0] v;
      v = CTRL_ONES | c.kept;
      v = v | (REG_W'(c.tft)    << CB_TFT_HI);
      v = v | (REG_W'(c.lmode)  << CB_LMODE);
      v = v | (REG_W'(c.tft)    << CB_TFT);
      v = v | (REG_W'(c.ien)    << CB_IEN);
      v = v | (REG_W'(c.mono)   << CB_MONO);
      v = v | (REG_W'(c.enable) << CB_EN);
      return v;
   endfunction

endpackage

// File: rtl/lcd_addr_decode.sv
module lcd_addr_decode
   import lcd_reg_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_TIM0 = ADDR_W'(OFF_TIM0);
   localparam logic [ADDR_W-1:0] A_TIM1 = ADDR_W'(OFF_TIM1);
   localparam logic [ADDR_W-1:0] A_TIM2 = ADDR_W'(OFF_TIM2);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_SUBP = ADDR_W'(OFF_SUBP);

   initial begin : p_elab_chk
      assert (ADDR_W >= 5) else $error("ADDR_W must cover offset 0x14");
   end

   always_comb begin
      if      (addr == A_CTRL) sel = SEL_CTRL;
      else if (addr == A_TIM0) sel = SEL_TIM0;
      else if (addr == A_TIM1) sel = SEL_TIM1;
      else if (addr == A_TIM2) sel = SEL_TIM2;
      else if (addr == A_STAT) sel = SEL_STAT;
      else if (addr == A_SUBP) sel = SEL_SUBP;
      else                     sel = SEL_NONE;
   end

endmodule

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
   import lcd_reg_pkg::*;
#(
   parameter int unsigned DIM_W = 10,
   localparam int unsigned FLD_W = REG_W - DIM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          sel,
   input  logic [REG_W-1:0]  wdata,
   input  logic              sync_evt,
   output ctl_fields_t       ctl,
   output logic [FLD_W-1:0]  tim0_fld,
   output logic [DIM_W:0]    width,
   output logic [FLD_W-1:0]  tim1_fld,
   output logic [DIM_W:0]    height,
   output logic [REG_W-1:0]  tim2,
   output logic [REG_W-1:0]  subp,
   output logic              act_on,
   output logic              act_off,
   output logic              mark_frame,
   output logic              eng_start,
   output logic              eng_stop
);

   initial begin : p_elab_chk
      assert (DIM_W >= 1 && DIM_W <= 16) else $error("DIM_W out of range");
   end

   logic ctl_wr, tim0_wr, tim1_wr, tim2_wr, subp_wr;
   logic en_req;

   assign ctl_wr  = wr_en && (sel == SEL_CTRL);
   assign tim0_wr = wr_en && (sel == SEL_TIM0);
   assign tim1_wr = wr_en && (sel == SEL_TIM1);
   assign tim2_wr = wr_en && (sel == SEL_TIM2);
   assign subp_wr = wr_en && (sel == SEL_SUBP);

   assign en_req     = ctl_wr ? wdata[CB_EN] : ctl.enable;
   assign act_on     = ctl_wr && wdata[CB_EN] && !ctl.enable && !sync_evt;
   assign act_off    = ctl_wr && !wdata[CB_EN] && ctl.enable;
   assign mark_frame = act_off && (wdata[CB_LMODE+1:CB_LMODE] != LMODE_PAL_ONLY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl       <= '0;
         tim0_fld  <= '0;
         width     <= '0;
         tim1_fld  <= '0;
         height    <= '0;
         tim2      <= '0;
         subp      <= '0;
         eng_start <= 1'b0;
         eng_stop  <= 1'b0;
      end else begin
         eng_start  <= act_on;
         eng_stop   <= act_off;
         ctl.enable <= sync_evt ? 1'b0 : en_req;
         if (ctl_wr) begin
            ctl.lmode <= wdata[CB_LMODE+1:CB_LMODE];
            ctl.tft   <= wdata[CB_TFT];
            ctl.ien   <= wdata[CB_IEN+1:CB_IEN];
            ctl.mono  <= wdata[CB_MONO];
            ctl.kept  <= wdata & CTRL_KEEP;
         end
         if (tim0_wr) begin
            tim0_fld <= wdata[REG_W-1:DIM_W];
            width    <= (DIM_W+1)'(wdata[DIM_W-1:0]) + (DIM_W+1)'(1);
         end
         if (tim1_wr) begin
            tim1_fld <= wdata[REG_W-1:DIM_W];
            height   <= (DIM_W+1)'(wdata[DIM_W-1:0]) + (DIM_W+1)'(1);
         end
         if (tim2_wr) tim2 <= wdata;
         if (subp_wr) subp <= wdata & SUBP_KEEP;
      end
   end

   // R7: start and stop never overlap
   a_r7_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_start && eng_stop));
   // R7: start pulse coincides with a fresh enable
   a_r7_start_enable: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (ctl.enable && !$past(ctl.enable)));
   // R7: pulse lasts one cycle
   a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   // R10: engine sync error drops enable
   a_r10_sync_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
      sync_evt |=> !ctl.enable);
   // R5: subpanel never holds masked-off bits
   a_r5_subp_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (subp & ~SUBP_KEEP) == '0);

endmodule

// File: rtl/lcd_status_irq.sv
module lcd_status_irq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       act_on,
   input  logic       act_off,
   input  logic       mark_frame,
   input  logic       evt_palette,
   input  logic       evt_sync,
   input  logic [1:0] ien,
   output logic       st_pal,
   output logic       st_sync,
   output logic       st_frame,
   output logic       irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_pal   <= 1'b0;
         st_sync  <= 1'b0;
         st_frame <= 1'b0;
      end else begin
         st_pal   <= evt_palette | (st_pal & ~act_on);
         st_sync  <= evt_sync | (st_sync & ~act_off);
         st_frame <= mark_frame | (st_frame & ~act_on);
      end
   end

   assign irq = (st_frame & ien[0]) | (st_pal & ien[1]) | st_sync;

   // R9: palette event is visible next cycle
   a_r9_palette_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt_palette |=> st_pal);
   // R11: sync error always interrupts
   a_r11_sync_irq: assert property (@(posedge clk) disable iff (!rst_n)
      st_sync |-> irq);
   // R8: stop without new sync event clears sync error
   a_r8_stop_clears_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (act_off && !evt_sync) |=> !st_sync);
   // R8: stop outside palette-only mode marks frame done
   a_r8_stop_frame: assert property (@(posedge clk) disable iff (!rst_n)
      mark_frame |=> st_frame);

endmodule

// File: rtl/lcd_read_mux.sv
module lcd_read_mux
   import lcd_reg_pkg::*;
#(
   parameter int unsigned DIM_W    = 10,
   parameter bit          READ_REG = 1'b0,
   localparam int unsigned FLD_W   = REG_W - DIM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  reg_sel_e          sel,
   input  ctl_fields_t       ctl,
   input  logic [FLD_W-1:0]  tim0_fld,
   input  logic [DIM_W:0]    width,
   input  logic [FLD_W-1:0]  tim1_fld,
   input  logic [DIM_W:0]    height,
   input  logic [REG_W-1:0]  tim2,
   input  logic [REG_W-1:0]  subp,
   input  logic              st_pal,
   input  logic              st_sync,
   input  logic              st_frame,
   output logic [REG_W-1:0]  rdata
);

   logic [REG_W-1:0] img;

   always_comb begin
      case (sel)
         SEL_CTRL: img = ctl_image(ctl);
         SEL_TIM0: img = {tim0_fld, {DIM_W{1'b0}}}
                         | (REG_W'(width) - REG_W'(1)) | TIM0_ONES;
         SEL_TIM1: img = {tim1_fld, {DIM_W{1'b0}}}
                         | (REG_W'(height) - REG_W'(1));
         SEL_TIM2: img = tim2 | TIM2_ONES;
         SEL_STAT: img = (REG_W'(st_pal)   << SB_PAL)
                       | (REG_W'(st_sync)  << SB_SYNC)
                       | (REG_W'(st_frame) << SB_FRAME);
         SEL_SUBP: img = subp;
         default:  img = '0;
      endcase
   end

   generate
      if (READ_REG == 1'b0) begin : g_comb
         assign rdata = rd_en ? img : '0;
         // R6: unmapped offsets read zero
         a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && sel == SEL_NONE) |-> (rdata == '0));
      end else begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_en ? img : '0;
         end
         // R6: unmapped offsets read zero
         a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && sel == SEL_NONE) |=> (rdata == '0));
      end
   endgenerate

endmodule

// File: rtl/lcd_ctl_regs.sv
module lcd_ctl_regs
   import lcd_reg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DIM_W    = 10,
   parameter bit          READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              evt_palette,
   input  logic              evt_sync_err,
   output logic              eng_start,
   output logic              eng_stop,
   output logic              cfg_enable,
   output logic [1:0]        cfg_load_mode,
   output logic              cfg_tft,
   output logic              cfg_mono,
   output logic [DIM_W:0]    cfg_width,
   output logic [DIM_W:0]    cfg_height,
   output logic              irq
);

   localparam int unsigned FLD_W = REG_W - DIM_W;

   reg_sel_e         sel;
   ctl_fields_t      ctl;
   logic [FLD_W-1:0] tim0_fld, tim1_fld;
   logic [REG_W-1:0] tim2, subp;
   logic             act_on, act_off, mark_frame;
   logic             st_pal, st_sync, st_frame;

   lcd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   lcd_cfg_regs #(.DIM_W(DIM_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_wr),
      .sel        (sel),
      .wdata      (bus_wdata),
      .sync_evt   (evt_sync_err),
      .ctl        (ctl),
      .tim0_fld   (tim0_fld),
      .width      (cfg_width),
      .tim1_fld   (tim1_fld),
      .height     (cfg_height),
      .tim2       (tim2),
      .subp       (subp),
      .act_on     (act_on),
      .act_off    (act_off),
      .mark_frame (mark_frame),
      .eng_start  (eng_start),
      .eng_stop   (eng_stop)
   );

   lcd_status_irq u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_on      (act_on),
      .act_off     (act_off),
      .mark_frame  (mark_frame),
      .evt_palette (evt_palette),
      .evt_sync    (evt_sync_err),
      .ien         (ctl.ien),
      .st_pal      (st_pal),
      .st_sync     (st_sync),
      .st_frame    (st_frame),
      .irq         (irq)
   );

   lcd_read_mux #(.DIM_W(DIM_W), .READ_REG(READ_REG)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (bus_rd),
      .sel      (sel),
      .ctl      (ctl),
      .tim0_fld (tim0_fld),
      .width    (cfg_width),
      .tim1_fld (tim1_fld),
      .height   (cfg_height),
      .tim2     (tim2),
      .subp     (subp),
      .st_pal   (st_pal),
      .st_sync  (st_sync),
      .st_frame (st_frame),
      .rdata    (bus_rdata)
   );

   assign cfg_enable    = ctl.enable;
   assign cfg_load_mode = ctl.lmode;
   assign cfg_tft       = ctl.tft;
   assign cfg_mono      = ctl.mono;

   // R10: engine sync error gives no stop pulse
   a_r10_no_stop_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_sync_err && !(bus_wr && sel == SEL_CTRL)) |=> !eng_stop);
   // R6: status writes do not touch flags
   a_r6_stat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_STAT && !evt_palette && !evt_sync_err) |=> $stable(st_pal));

endmodule

// File: tb/tb_lcd_ctl_regs.sv
`timescale 1ns/1ps
module tb_lcd_ctl_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        evt_palette = 1'b0, evt_sync_err = 1'b0;
   logic        eng_start, eng_stop, cfg_enable, cfg_tft, cfg_mono, irq;
   logic [1:0]  cfg_load_mode;
   logic [10:0] cfg_width, cfg_height;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   lcd_ctl_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_palette(evt_palette), .evt_sync_err(evt_sync_err),
      .eng_start(eng_start), .eng_stop(eng_stop), .cfg_enable(cfg_enable),
      .cfg_load_mode(cfg_load_mode), .cfg_tft(cfg_tft), .cfg_mono(cfg_mono),
      .cfg_width(cfg_width), .cfg_height(cfg_height), .irq(irq)
   );

   localparam logic [7:0] A_CTRL = 8'h00, A_T0 = 8'h04, A_T1 = 8'h08,
                          A_T2 = 8'h0C, A_ST = 8'h10, A_SP = 8'h14;

   function automatic logic [31:0] ctl_exp(input logic [31:0] w, input logic en);
      logic [31:0] v;
      v = 32'hFE000C34 | (w & 32'h01CFF300);
      v = v | (32'(w[7]) << 23) | (32'(w[21:20]) << 20) | (32'(w[7]) << 7);
      v = v | (32'(w[4:3]) << 3) | (32'(w[1]) << 1) | 32'(en);
      return v;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_evt(input logic [7:0] a, input logic [31:0] d,
                         input logic pal, input logic snc);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      evt_palette = pal; evt_sync_err = snc;
      @(negedge clk);
      bus_wr = 1'b0; evt_palette = 1'b0; evt_sync_err = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_evt(a, d, 1'b0, 1'b0);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic pulse(input logic pal, input logic snc);
      @(negedge clk);
      evt_palette = pal; evt_sync_err = snc;
      @(negedge clk);
      evt_palette = 1'b0; evt_sync_err = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(A_ST, v);   chk("R1 status", v, 32'h0);
      rd(A_SP, v);   chk("R1 subpanel", v, 32'h0);
      rd(A_CTRL, v); chk("R1 control", v, 32'hFE000C34);
      rd(A_T0, v);   chk("R1 timing0", v, 32'hFFFFFFFF);
      rd(A_T1, v);   chk("R1 timing1", v, 32'hFFFFFFFF);
      rd(A_T2, v);   chk("R1 timing2", v, 32'hFC000000);
      chk("R1 outputs", {28'h0, irq, eng_start, eng_stop, cfg_enable}, 32'h0);
      chk("R1 width", 32'(cfg_width), 32'h0);
   endtask

   task automatic t_ctrl_fields;
      logic [31:0] v;
      wr(A_CTRL, 32'hFFFFFFFE);
      rd(A_CTRL, v); chk("R2 all fields", v, ctl_exp(32'hFFFFFFFE, 1'b0));
      chk("R2 cfg fields", {28'h0, cfg_load_mode, cfg_tft, cfg_mono}, 32'hF);
      chk("R7 no start on same enable", 32'(eng_start), 32'h0);
      wr(A_CTRL, 32'h00800082);
      rd(A_CTRL, v); chk("R2 tft mirror", v, ctl_exp(32'h00800082, 1'b0));
      wr(A_CTRL, 32'h0);
      rd(A_CTRL, v); chk("R2 cleared", v, 32'hFE000C34);
   endtask

   task automatic t_timing;
      logic [31:0] v;
      wr(A_T0, 32'h00012345);
      rd(A_T0, v); chk("R3 timing0 read", v, 32'h0001234F);
      chk("R3 width", 32'(cfg_width), 32'h346);
      wr(A_T0, 32'hFFFFFFFF);
      rd(A_T0, v); chk("R3 timing0 max", v, 32'hFFFFFFFF);
      chk("R3 width max", 32'(cfg_width), 32'h400);
      wr(A_T1, 32'h0);
      rd(A_T1, v); chk("R4 timing1 zero", v, 32'h0);
      chk("R4 height one", 32'(cfg_height), 32'h1);
      wr(A_T1, 32'hABCD_E123);
      rd(A_T1, v); chk("R4 timing1 read", v, 32'hABCDE123);
      wr(A_T2, 32'h00001234);
      rd(A_T2, v); chk("R4 timing2 read", v, 32'hFC001234);
   endtask

   task automatic t_subpanel;
      logic [31:0] v;
      wr(A_SP, 32'hFFFFFFFF);
      rd(A_SP, v); chk("R5 subpanel mask", v, 32'hA1FFFFFF);
   endtask

   task automatic t_ignored;
      logic [31:0] v;
      wr(A_ST, 32'hFFFFFFFF);
      rd(A_ST, v); chk("R6 status write ignored", v, 32'h0);
      chk("R6 irq after status write", 32'(irq), 32'h0);
      wr(8'h18, 32'hFFFFFFFF);
      wr(8'h1C, 32'h00000001);
      rd(A_CTRL, v); chk("R6 control untouched", v, 32'hFE000C34);
      rd(A_SP, v);   chk("R6 subpanel untouched", v, 32'hA1FFFFFF);
      rd(A_T2, v);   chk("R6 timing2 untouched", v, 32'hFC001234);
      rd(8'h18, v);  chk("R6 unmapped 0x18", v, 32'h0);
      rd(8'h40, v);  chk("R6 unmapped 0x40", v, 32'h0);
      chk("R6 no start from unmapped", 32'(eng_start), 32'h0);
   endtask

   task automatic t_enable_cycle;
      logic [31:0] v;
      wr(A_CTRL, 32'h19);
      chk("R7 start pulse", {30'h0, eng_start, eng_stop}, 32'h2);
      @(negedge clk);
      chk("R7 start one cycle", 32'(eng_start), 32'h0);
      rd(A_ST, v); chk("R7 status after start", v, 32'h0);
      pulse(1'b1, 1'b0);
      rd(A_ST, v); chk("R9 palette set", v, 32'h40);
      chk("R11 palette irq", 32'(irq), 32'h1);
      wr(A_CTRL, 32'h18);
      chk("R7 stop pulse", {30'h0, eng_start, eng_stop}, 32'h1);
      rd(A_ST, v); chk("R8 frame done on stop", v, 32'h41);
      wr(A_CTRL, 32'h18);
      chk("R7 no second stop", 32'(eng_stop), 32'h0);
      wr(A_CTRL, 32'h19);
      rd(A_ST, v); chk("R7 enable clears flags", v, 32'h0);
      wr(A_CTRL, 32'h01);
      chk("R7 no pulse same enable", {30'h0, eng_start, eng_stop}, 32'h0);
      wr(A_CTRL, 32'h00);
      rd(A_ST, v); chk("R8 frame done", v, 32'h01);
      chk("R11 masked frame", 32'(irq), 32'h0);
   endtask

   task automatic t_loadmode1;
      logic [31:0] v;
      wr(A_CTRL, 32'h00100001);
      chk("R7 start lmode1", 32'(eng_start), 32'h1);
      wr(A_CTRL, 32'h00100000);
      chk("R8 stop lmode1", 32'(eng_stop), 32'h1);
      chk("R2 load mode", 32'(cfg_load_mode), 32'h1);
      rd(A_ST, v); chk("R8 no frame done in lmode1", v, 32'h0);
   endtask

   task automatic t_sync;
      logic [31:0] v;
      wr(A_CTRL, 32'h01);
      pulse(1'b0, 1'b1);
      rd(A_ST, v); chk("R10 sync flag", v, 32'h04);
      chk("R10 enable dropped", {30'h0, cfg_enable, eng_stop}, 32'h0);
      chk("R11 sync irq", 32'(irq), 32'h1);
      rd(A_CTRL, v); chk("R10 control enable bit", v, 32'hFE000C34);
      wr(A_CTRL, 32'h00);
      chk("R10 no stop when already off", 32'(eng_stop), 32'h0);
      rd(A_ST, v); chk("R8 sync kept without stop", v, 32'h04);
      wr(A_CTRL, 32'h01);
      chk("R7 restart", 32'(eng_start), 32'h1);
      rd(A_ST, v); chk("R7 sync survives start", v, 32'h04);
      wr(A_CTRL, 32'h00);
      rd(A_ST, v); chk("R8 stop clears sync", v, 32'h01);
      chk("R11 irq low", 32'(irq), 32'h0);
   endtask

   task automatic t_collide;
      logic [31:0] v;
      wr_evt(A_CTRL, 32'h01, 1'b0, 1'b1);
      chk("R10 start suppressed", {30'h0, eng_start, cfg_enable}, 32'h0);
      rd(A_ST, v); chk("R10 collide status", v, 32'h05);
      wr(A_CTRL, 32'h01);
      rd(A_ST, v); chk("R7 start after collide", v, 32'h04);
      wr(A_CTRL, 32'h00);
      wr_evt(A_CTRL, 32'h01, 1'b1, 1'b0);
      chk("R7 start with palette", 32'(eng_start), 32'h1);
      rd(A_ST, v); chk("R9 set wins over clear", v, 32'h40);
      wr_evt(A_CTRL, 32'h00, 1'b0, 1'b1);
      chk("R7 stop with sync", 32'(eng_stop), 32'h1);
      rd(A_ST, v); chk("R9 sync set wins", v, 32'h45);
   endtask

   task automatic t_irq_mask;
      logic [31:0] v;
      wr(A_CTRL, 32'h01);
      wr(A_CTRL, 32'h00);
      rd(A_ST, v); chk("R8 clean frame", v, 32'h01);
      wr(A_CTRL, 32'h08);
      chk("R11 frame enable", 32'(irq), 32'h1);
      wr(A_CTRL, 32'h10);
      chk("R11 palette enable only", 32'(irq), 32'h0);
      wr(A_CTRL, 32'h00);
      chk("R11 none enabled", 32'(irq), 32'h0);
   endtask

   initial begin : p_watchdog
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : p_main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl_fields();
      t_timing();
      t_subpanel();
      t_ignored();
      t_enable_cycle();
      t_loadmode1();
      t_sync();
      t_collide();
      t_irq_mask();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule